// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block runs the bus cycles of one DMA channel after the channel has been given a start address and a word count. When the channel request line goes high, the sequencer asks the host for the bus by raising a hold request. When the host grants the bus with hold acknowledge, the sequencer walks through a fixed set of states. It strobes the upper address byte out on the data lines. It then acknowledges the channel and presents the low address byte on the address pins for each transfer, stepping the address by one between transfers.

Transfers run back to back in block fashion until the word count passes zero. The sequencer then gives the bus back and waits in idle. Between transfers, a continuation state shows the new address. If the upper address byte has changed, the sequencer strobes the new byte again. If it has not changed, the sequencer goes straight to the next transfer and skips the strobe. The polarity of the channel acknowledge output comes from a command bit held outside the block.

Top module: `dma_seq_top`

## Requirements
- R1: Reset puts the sequencer in idle with hrq, aen, adstb, dack-active, db_en low and addr_lo/db_out zero, and clears the current address and count to zero, so an unprogrammed request yields exactly one transfer at address 0.
- R2: In idle, dreq high at a clock edge makes hrq high after that edge, while aen, adstb and the acknowledge stay inactive; hrq then stays high until hlda is seen.
- R3: The edge after hlda is seen in the request state enters the first bus state, where hrq and aen are high and adstb, acknowledge and db_en are low.
- R4: The strobe state follows the first bus state for one cycle: adstb, db_en and acknowledge are active, addr_lo carries the current address bits [LO_W-1:0] and db_out carries bits [ADDR_W-1:LO_W].
- R5: Each transfer takes two cycles after a strobe or continuation state, with adstb low, hrq, aen and acknowledge active, and addr_lo holding the current address.
- R6: After a transfer that is not the last, a continuation state presents the current address plus one with adstb low; next comes the strobe state if the new low byte is zero (the upper byte changed), otherwise a transfer directly.
- R7: A loaded count N gives N+1 transfers at consecutive addresses starting from the loaded address; the count drops by one per transfer and the last transfer is the one taken with count zero (the count then wraps to all ones).
- R8: After the last transfer the sequencer returns to idle with hrq, aen and acknowledge inactive.
- R9: With ack_hi = 1 the dack pin is 1 when the acknowledge is active; with ack_hi = 0 the dack pin is 0 when active and 1 otherwise.
- R10: If hlda is low at a clock edge in any bus state, the sequencer goes to idle at that edge (aen low after it) and restarts the current transfer when the bus is granted again.
- R11: cfg_load loads the start address and count only in idle; a pulse while a run is in progress has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dreq | input | 1 | Channel request |
| hlda | input | 1 | Bus grant from host |
| ack_hi | input | 1 | Command bit: acknowledge active high when 1 |
| cfg_load | input | 1 | Load start address and count (idle only) |
| cfg_addr | input | ADDR_W | Start address |
| cfg_count | input | CNT_W | Word count (transfers minus one) |
| hrq | output | 1 | Hold request to host |
| aen | output | 1 | Address enable |
| adstb | output | 1 | Upper address byte strobe |
| dack | output | 1 | Channel acknowledge pin, polarity set by ack_hi |
| addr_lo | output | LO_W | Low address bits |
| db_out | output | ADDR_W-LO_W | Upper address byte on data lines |
| db_en | output | 1 | Data lines driven by the sequencer |

## Verification
The properties assume that hlda follows the host's view of hrq. They also assume that ack_hi behaves as a configuration bit that stays steady within a run. The idle-acknowledge property compares the pin against ack_hi in the same cycle, so the bench changes ack_hi only while the sequencer is idle. The bench drives hlda from the observed hrq, with random one-cycle drops to provoke abandoned transfers. It issues cfg_load pulses both in idle and in the middle of runs. The start addresses are biased toward the top of a page so that upper-byte crossings happen often.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_S1   = 3'd2,
    ST_S2   = 3'd3,
    ST_S3   = 3'd4,
    ST_S4   = 3'd5,
    ST_SB   = 3'd6
  } seq_st_t;
endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              adv,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic              cnt_zero,
  output logic              new_page
);
  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic page_start(input logic [ADDR_W-1:0] a);
    return a[LO_W-1:0] == '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
    end else if (load_en) begin
      cur_addr <= cfg_addr;
      cur_cnt  <= cfg_count;
    end else if (adv) begin
      cur_addr <= addr_inc(cur_addr);
      cur_cnt  <= cnt_dec(cur_cnt);
    end
  end

  assign cnt_zero = (cur_cnt == '0);
  assign new_page = page_start(cur_addr);
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    dreq,
  input  logic    hlda,
  input  logic    cnt_zero,
  input  logic    new_page,
  output seq_st_t state,
  output logic    adv,
  output logic    last_xfer,
  output logic    step
);
  seq_st_t nxt;

  assign adv       = (state == ST_S4) && hlda;
  assign last_xfer = adv && cnt_zero;
  assign step      = adv && !cnt_zero;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (dreq) nxt = ST_REQ;
      ST_REQ:  if (hlda) nxt = ST_S1;
      ST_S1:   nxt = hlda ? ST_S2 : ST_IDLE;
      ST_S2:   nxt = hlda ? ST_S3 : ST_IDLE;
      ST_S3:   nxt = hlda ? ST_S4 : ST_IDLE;
      ST_S4:   nxt = (!hlda || cnt_zero) ? ST_IDLE : ST_SB;
      ST_SB:   nxt = !hlda ? ST_IDLE : (new_page ? ST_S2 : ST_S3);
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/dma_seq_outdec.sv
module dma_seq_outdec
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8,
  localparam int HI_W  = ADDR_W - LO_W
) (
  input  seq_st_t           state,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              ack_hi,
  output logic              hrq,
  output logic              aen,
  output logic              adstb,
  output logic              dack_act,
  output logic              dack,
  output logic [LO_W-1:0]   addr_lo,
  output logic [HI_W-1:0]   db_out,
  output logic              db_en
);
  always_comb begin
    hrq      = (state != ST_IDLE);
    aen      = (state != ST_IDLE) && (state != ST_REQ);
    adstb    = (state == ST_S2);
    dack_act = (state == ST_S2) || (state == ST_S3) ||
               (state == ST_S4) || (state == ST_SB);
    db_en    = adstb;
    addr_lo  = dack_act ? cur_addr[LO_W-1:0] : '0;
    db_out   = db_en ? cur_addr[ADDR_W-1:LO_W] : '0;
    dack     = ack_hi ? dack_act : !dack_act;
  end
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int LO_W   = 8,
  localparam int HI_W  = ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dreq,
  input  logic              hlda,
  input  logic              ack_hi,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              hrq,
  output logic              aen,
  output logic              adstb,
  output logic              dack,
  output logic [LO_W-1:0]   addr_lo,
  output logic [HI_W-1:0]   db_out,
  output logic              db_en
);
  seq_st_t           state;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt;
  logic              cnt_zero, new_page, adv, last_xfer, step;
  logic              dack_act, is_idle, load_en;

  assign is_idle = (state == ST_IDLE);
  assign load_en = cfg_load && is_idle;

  dma_seq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LO_W(LO_W)) u_regs (
    .clk(clk), .rst(rst), .load_en(load_en), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .adv(adv), .cur_addr(cur_addr),
    .cur_cnt(cur_cnt), .cnt_zero(cnt_zero), .new_page(new_page)
  );

  dma_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .dreq(dreq), .hlda(hlda), .cnt_zero(cnt_zero),
    .new_page(new_page), .state(state), .adv(adv),
    .last_xfer(last_xfer), .step(step)
  );

  dma_seq_outdec #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_out (
    .state(state), .cur_addr(cur_addr), .ack_hi(ack_hi), .hrq(hrq),
    .aen(aen), .adstb(adstb), .dack_act(dack_act), .dack(dack),
    .addr_lo(addr_lo), .db_out(db_out), .db_en(db_en)
  );
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              dreq,
  input logic              hlda,
  input logic              ack_hi,
  input logic              hrq,
  input logic              aen,
  input logic              adstb,
  input logic              dack,
  input logic              db_en,
  input logic              is_idle,
  input logic              step,
  input logic              last_xfer,
  input logic [ADDR_W-1:0] cur_addr
);
  AST_REQ_RAISES_HOLD: assert property (@(posedge clk) disable iff (rst) (is_idle && dreq) |=> hrq); // R2
  AST_FIRST_STATE_QUIET: assert property (@(posedge clk) disable iff (rst) $rose(aen) |-> (!adstb && !db_en)); // R3
  AST_STROBE_IN_BUS: assert property (@(posedge clk) disable iff (rst) adstb |-> (aen && hrq && db_en)); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) adstb |=> !adstb); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst) step |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1))); // R6
  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (rst) last_xfer |=> (!hrq && !aen)); // R8
  AST_IDLE_ACK_OFF: assert property (@(posedge clk) disable iff (rst) (!aen && ack_hi) |-> !dack); // R9
  AST_GRANT_LOSS: assert property (@(posedge clk) disable iff (rst) (aen && !hlda) |=> !aen); // R10
endmodule

bind dma_seq_top dma_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .dreq(dreq), .hlda(hlda), .ack_hi(ack_hi),
  .hrq(hrq), .aen(aen), .adstb(adstb), .dack(dack), .db_en(db_en),
  .is_idle(is_idle), .step(step), .last_xfer(last_xfer), .cur_addr(cur_addr)
);

// File: tb/dma_seq_top_test.sv
module dma_seq_top_test;
  localparam int AW = 16, CW = 16, LW = 8, HW = AW - LW;

  logic clk = 1'b0, rst = 1'b1, dreq = 1'b0, hlda = 1'b0, ack_hi = 1'b1, cfg_load = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic hrq, aen, adstb, dack, db_en;
  logic [LW-1:0] addr_lo;
  logic [HW-1:0] db_out;

  int nchk = 0, nerr = 0;
  int ms = 0;            // 0 idle 1 req 2 s1 3 s2 4 s3 5 s4 6 cont
  logic [AW-1:0] ma = '0;
  logic [CW-1:0] mc = '0;
  int n_x, n_stb;
  logic [LW-1:0] seen [0:15];
  logic [HW-1:0] stb_db [0:7];

  always #4 clk = ~clk;

  dma_seq_top uut (
    .clk(clk), .rst(rst), .dreq(dreq), .hlda(hlda), .ack_hi(ack_hi),
    .cfg_load(cfg_load), .cfg_addr(cfg_addr), .cfg_count(cfg_count),
    .hrq(hrq), .aen(aen), .adstb(adstb), .dack(dack), .addr_lo(addr_lo),
    .db_out(db_out), .db_en(db_en)
  );

  function automatic logic [AW-1:0] nxt_addr(input logic [AW-1:0] a);
    return a + 1;
  endfunction
  function automatic bit crossed(input logic [AW-1:0] a);
    return (a % (1 << LW)) == 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model from the requirements
  always @(posedge clk) begin
    if (rst) begin
      ms <= 0; ma <= '0; mc <= '0;
    end else begin
      case (ms)
        0: begin
          if (cfg_load) begin ma <= cfg_addr; mc <= cfg_count; end
          if (dreq) ms <= 1;
        end
        1: if (hlda) ms <= 2;
        2: ms <= hlda ? 3 : 0;
        3: ms <= hlda ? 4 : 0;
        4: ms <= hlda ? 5 : 0;
        5: if (!hlda) ms <= 0;
           else begin
             ma <= nxt_addr(ma); mc <= mc - 1;
             ms <= (mc == 0) ? 0 : 6;
           end
        6: ms <= !hlda ? 0 : (crossed(ma) ? 3 : 4);
        default: ms <= 0;
      endcase
    end
  end

  // compare late in the cycle
  always @(posedge clk) begin
    #6;
    begin
      string t;
      bit act;
      case (ms)
        0: t = rst ? "R1" : "R8";
        1: t = "R2";
        2: t = "R3";
        3: t = "R4";
        6: t = "R6";
        default: t = "R5";
      endcase
      act = (ms >= 3);
      chk(t, "hrq", hrq, ms != 0);
      chk(t, "aen", aen, ms >= 2);
      chk(t, "adstb", adstb, ms == 3);
      chk(t, "db_en", db_en, ms == 3);
      chk(ack_hi ? t : "R9", "dack", dack, ack_hi ? act : !act);
      chk(t, "addr_lo", addr_lo, act ? ma[LW-1:0] : 0);
      chk(t, "db_out", db_out, (ms == 3) ? ma[AW-1:LW] : 0);
    end
  end

  task automatic do_run(input bit load, input logic [AW-1:0] a, input logic [CW-1:0] c,
                        input bit poke);
    bit started = 0, poked = 0;
    logic [LW-1:0] last = '0;
    n_x = 0; n_stb = 0;
    if (load) begin
      @(negedge clk); cfg_load = 1; cfg_addr = a; cfg_count = c;
      @(negedge clk); cfg_load = 0;
    end
    dreq = 1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      hlda = hrq;
      cfg_load = 0;
      if (poke && n_x == 1 && !poked) begin
        cfg_load = 1; cfg_addr = 16'h0f00; cfg_count = 9; poked = 1;
      end
      if (aen) started = 1;
      if (adstb && n_stb < 8) begin stb_db[n_stb] = db_out; n_stb++; end
      if ((dack == ack_hi) && (n_x == 0 || addr_lo != last)) begin
        if (n_x < 16) seen[n_x] = addr_lo;
        n_x++; last = addr_lo;
      end
      if (started && !hrq) break;
    end
    dreq = 0; hlda = 0; cfg_load = 0;
    @(negedge clk);
  endtask

  task automatic rnd_run();
    bit started = 0;
    logic [AW-1:0] a;
    @(negedge clk);
    ack_hi = ($urandom % 4) != 0;
    a = $urandom;
    if ($urandom % 2) a[LW-1:0] = 8'hFC | LW'($urandom % 4);
    cfg_load = 1; cfg_addr = a; cfg_count = CW'($urandom % 7);
    @(negedge clk); cfg_load = 0; dreq = 1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      hlda = hrq && (($urandom % 10) != 0);
      cfg_load = ($urandom % 15) == 0;
      cfg_addr = $urandom; cfg_count = CW'($urandom % 5);
      if (aen) started = 1;
      if (started && ms == 0 && mc == '1) break;
    end
    dreq = 0; hlda = 0; cfg_load = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a));
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);

    // R1: unprogrammed request -> one transfer at address zero
    do_run(0, '0, '0, 0);
    chk("R1", "transfers", n_x, 1);
    chk("R1", "addr", seen[0], 0);

    // R7: count 3 from 0
    do_run(1, 16'h0000, 3, 0);
    chk("R7", "transfers", n_x, 4);
    for (int i = 0; i < 4; i++) chk("R7", "seq addr", seen[i], i);
    chk("R4", "strobes no crossing", n_stb, 1);

    // R6: page crossing re-strobes upper byte
    do_run(1, 16'h01FE, 3, 0);
    chk("R7", "transfers crossing", n_x, 4);
    chk("R6", "addr after wrap", seen[2], 0);
    chk("R6", "strobes", n_stb, 2);
    chk("R6", "first upper", stb_db[0], 8'h01);
    chk("R6", "new upper", stb_db[1], 8'h02);

    // R9: active-low acknowledge
    @(negedge clk); ack_hi = 0;
    do_run(1, 16'h0010, 1, 0);
    chk("R9", "transfers low ack", n_x, 2);
    @(negedge clk); ack_hi = 1;

    // R11: load during run ignored
    do_run(1, 16'h0040, 2, 1);
    chk("R11", "transfers", n_x, 3);
    chk("R11", "last addr", seen[2], 8'h42);

    // R10: grant drop in strobe state
    @(negedge clk); cfg_load = 1; cfg_addr = 16'h0080; cfg_count = 5;
    @(negedge clk); cfg_load = 0; dreq = 1;
    for (int k = 0; k < 20 && !adstb; k++) begin @(negedge clk); hlda = hrq; end
    hlda = 0;
    @(posedge clk); #6;
    chk("R10", "aen after drop", aen, 0);
    chk("R10", "hrq after drop", hrq, 0);
    dreq = 0;
    repeat (3) @(negedge clk);

    for (int r = 0; r < 150; r++) rnd_run();

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule